// File: doc/BRIEF.md
# Display Refill FIFO with Programmable Depth

This block sits between a video memory fetch engine and the pixel pipeline. It holds words fetched from display memory and hands them to the pixel side on demand. Two runtime fields control it: one sets how many of its slots are in use (eight, four or two), and one sets how many slots must be free before it asks the memory arbiter for another fetch. The fetch engine pushes words in with a valid/ready handshake; the pixel side pops words whenever it needs data.

Two width options shape the data path. On the memory side, a narrow-path bit makes every accepted push carry only sixteen bits, and two pushes are joined into one stored word. On the pixel side, a half-output bit makes each pop deliver sixteen bits, so a stored word lasts for two pops. A sticky flag records any pop made while nothing is stored, and the software-visible logic outside the block clears it by pulsing a clear input.

Changing the depth field empties the FIFO at once, so pointers never refer to slots beyond the new depth.

Top module: `drf_top`

## Requirements
- R1: The depth code gives the usable depth: 0 gives 8 slots, 1 gives 4, 2 and 3 give 2. `in_ready` is high only while `level` is below that depth and no depth change is in progress; `full` is high when `level` equals the depth.
- R2: `mem_req` is high when the number of free slots (depth minus `level`) is at least the threshold; the threshold is the request code plus one (code 0 means one free slot, code 3 means four).
- R3: The threshold is limited to depth minus one, so a 2-slot FIFO requests whenever one slot is free and a 4-slot FIFO with code 3 requests at three free slots.
- R4: In any cycle where `cfg_depth` differs from its value in the previous cycle, the FIFO is emptied, the half-word states are cleared, and pushes and pops of that cycle are discarded; `level` is 0 in the next cycle.
- R5: In full-word output mode (`cfg_half`=0) words leave in the order they were accepted, `out_data` shows the oldest word whenever `out_valid` is high, and each pop removes one word.
- R6: In half output mode (`cfg_half`=1) `out_data[15:0]` shows bits 15:0 of the oldest word first, then bits 31:16 after one pop, with `out_data[31:16]` zero; the word is removed on the second pop.
- R7: With `cfg_narrow`=1 each accepted push supplies `in_data[15:0]`; the first push of a pair becomes bits 15:0 and the second bits 31:16 of one stored word, which enters the FIFO on the second push.
- R8: A pop while `out_valid` is low (outside a depth change) sets `underrun`, which stays set until a cycle with `underrun_clr` high; a new underrun in the same cycle as the clear leaves it set.
- R9: After reset `level` is 0, `out_valid` and `underrun` are 0, `mem_req` is 1 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_depth | input | 2 | Depth code |
| cfg_req | input | 2 | Refill request threshold code |
| cfg_half | input | 1 | Deliver 16-bit halves to the pixel side |
| cfg_narrow | input | 1 | 16-bit memory data path, two pushes per word |
| in_valid | input | 1 | Push request from the fetch engine |
| in_data | input | 32 | Pushed data |
| in_ready | output | 1 | Push accepted this cycle when high with `in_valid` |
| out_pop | input | 1 | Pop request from the pixel side |
| out_valid | output | 1 | A word is stored |
| out_data | output | 32 | Oldest word or selected half |
| mem_req | output | 1 | Refill request to the memory arbiter |
| level | output | 4 | Number of stored words |
| full | output | 1 | Stored words equal the usable depth |
| underrun | output | 1 | Sticky pop-while-empty flag |
| underrun_clr | input | 1 | Clears `underrun` |

## Verification
The hardest situation to reach is a depth change that lands while a narrow push pair is half assembled and a half-output word is half consumed, because both partial states must be discarded along with the stored words. The stimulus reaches it by running long random traffic in which the width modes and the request code change often and the depth code changes now and then, so changes fall at arbitrary fill levels and half positions; directed phases first cover each depth, the threshold clamp, pops on an empty FIFO and a clear that coincides with a new underrun.

// File: rtl/drf_pkg.sv
package drf_pkg;
  // Usable slot count for a depth code, given the largest depth.
  function automatic int unsigned slots_for(input logic [1:0] code,
                                            input int unsigned max_slots);
    case (code)
      2'd0:    return max_slots;
      2'd1:    return max_slots / 2;
      default: return max_slots / 4;
    endcase
  endfunction
endpackage

// File: rtl/drf_store.sv
module drf_store #(
  parameter int DATA_W = 32,
  parameter int SLOTS  = 8,
  localparam int AW    = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [SLOTS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/drf_packer.sv
module drf_packer #(
  parameter int DATA_W = 32,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              narrow,
  input  logic              accept,
  input  logic [DATA_W-1:0] din,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_word
);
  logic              lo_have;
  logic [HALF_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      lo_have <= 1'b0;
      lo_q    <= '0;
    end else if (accept && narrow) begin
      lo_have <= ~lo_have;
      if (!lo_have) lo_q <= din[HALF_W-1:0];
    end
  end

  always_comb begin
    if (narrow) begin
      wr_en   = accept && lo_have;
      wr_word = {din[HALF_W-1:0], lo_q};
    end else begin
      wr_en   = accept;
      wr_word = din;
    end
  end
endmodule

// File: rtl/drf_top.sv
module drf_top #(
  parameter int DATA_W    = 32,
  parameter int MAX_SLOTS = 8,
  localparam int AW       = $clog2(MAX_SLOTS),
  localparam int CNT_W    = $clog2(MAX_SLOTS + 1),
  localparam int HALF_W   = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_depth,
  input  logic [1:0]        cfg_req,
  input  logic              cfg_half,
  input  logic              cfg_narrow,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              out_pop,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              mem_req,
  output logic [CNT_W-1:0]  level,
  output logic              full,
  output logic              underrun,
  input  logic              underrun_clr
);
  import drf_pkg::*;

  logic [1:0]        depth_q;
  logic              flush;
  logic [CNT_W-1:0]  slots, thr_raw, thr_lim, thr, free_cnt;
  logic [CNT_W-1:0]  count;
  logic [AW-1:0]     wr_ptr, rd_ptr, ptr_last;
  logic              accept, wr_en, rd_hit, remove, half_sel;
  logic [DATA_W-1:0] wr_word, rd_word;

  assign flush    = (cfg_depth != depth_q);
  assign slots    = CNT_W'(slots_for(depth_q, MAX_SLOTS));
  assign ptr_last = AW'(slots - CNT_W'(1));
  assign thr_raw  = CNT_W'(cfg_req) + CNT_W'(1);
  assign thr_lim  = slots - CNT_W'(1);
  assign thr      = (thr_raw > thr_lim) ? thr_lim : thr_raw;
  assign free_cnt = slots - count;

  assign in_ready  = (count < slots) && !flush;
  assign accept    = in_valid && in_ready;
  assign out_valid = (count != '0);
  assign rd_hit    = out_pop && out_valid && !flush;
  assign remove    = rd_hit && (!cfg_half || half_sel);
  assign mem_req   = (free_cnt >= thr);
  assign full      = (count == slots);
  assign level     = count;

  drf_packer #(.DATA_W(DATA_W)) u_pack (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush),
    .narrow  (cfg_narrow),
    .accept  (accept),
    .din     (in_data),
    .wr_en   (wr_en),
    .wr_word (wr_word)
  );

  drf_store #(.DATA_W(DATA_W), .SLOTS(MAX_SLOTS)) u_store (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_ptr),
    .wdata (wr_word),
    .raddr (rd_ptr),
    .rdata (rd_word)
  );

  always_ff @(posedge clk) begin
    depth_q <= cfg_depth;
    if (rst || flush) begin
      count    <= '0;
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      half_sel <= 1'b0;
    end else begin
      count <= count + CNT_W'(wr_en) - CNT_W'(remove);
      if (wr_en) wr_ptr <= (wr_ptr == ptr_last) ? '0 : wr_ptr + AW'(1);
      if (remove) rd_ptr <= (rd_ptr == ptr_last) ? '0 : rd_ptr + AW'(1);
      if (rd_hit) half_sel <= cfg_half ? ~half_sel : 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) underrun <= 1'b0;
    else underrun <= (underrun && !underrun_clr) ||
                     (out_pop && !out_valid && !flush);
  end

  always_comb begin
    if (cfg_half)
      out_data = {{(DATA_W-HALF_W){1'b0}},
                  half_sel ? rd_word[DATA_W-1:HALF_W] : rd_word[HALF_W-1:0]};
    else
      out_data = rd_word;
  end
endmodule

// File: rtl/drf_checker.sv
module drf_checker #(
  parameter int MAX_SLOTS = 8,
  parameter int CNT_W     = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       cfg_depth,
  input logic             out_pop,
  input logic             underrun_clr,
  input logic [CNT_W-1:0] level,
  input logic             full,
  input logic             in_ready,
  input logic             mem_req,
  input logic             out_valid,
  input logic             underrun
);
  import drf_pkg::*;

  logic [1:0] seen_depth;
  always_ff @(posedge clk) seen_depth <= cfg_depth;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    int'(level) <= int'(slots_for(seen_depth, MAX_SLOTS))); // R1
  AST_FULL_BLOCKS_PUSH: assert property (@(posedge clk) disable iff (rst)
    full |-> !in_ready); // R1
  AST_REQ_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (level == '0) |-> mem_req); // R2
  AST_DEPTH_CHANGE_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (cfg_depth != seen_depth) |=> (level == '0)); // R4
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    (underrun && !underrun_clr) |=> underrun); // R8
  AST_UNDERRUN_SET: assert property (@(posedge clk) disable iff (rst)
    (out_pop && !out_valid && cfg_depth == seen_depth) |=> underrun); // R8
  AST_UNDERRUN_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (underrun_clr && out_valid) |=> !underrun); // R8
endmodule

bind drf_top drf_checker #(.MAX_SLOTS(MAX_SLOTS), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_depth    (cfg_depth),
  .out_pop      (out_pop),
  .underrun_clr (underrun_clr),
  .level        (level),
  .full         (full),
  .in_ready     (in_ready),
  .mem_req      (mem_req),
  .out_valid    (out_valid),
  .underrun     (underrun)
);

// File: tb/drf_top_tb.sv
module drf_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_depth = 2'd0, cfg_req = 2'd0;
  logic        cfg_half = 1'b0, cfg_narrow = 1'b0;
  logic        in_valid = 1'b0, out_pop = 1'b0, underrun_clr = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready, out_valid, mem_req, full, underrun;
  logic [31:0] out_data;
  logic [3:0]  level;

  int compared = 0, mismatched = 0;
  bit finished = 0;

  // reference model state
  logic [31:0] q[$];
  int          m_depth = 0;
  bit          m_lo_have = 0, m_hsel = 0, m_und = 0;
  logic [15:0] m_lo = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  drf_top u_dut (
    .clk(clk), .rst(rst), .cfg_depth(cfg_depth), .cfg_req(cfg_req),
    .cfg_half(cfg_half), .cfg_narrow(cfg_narrow), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .out_pop(out_pop),
    .out_valid(out_valid), .out_data(out_data), .mem_req(mem_req),
    .level(level), .full(full), .underrun(underrun),
    .underrun_clr(underrun_clr)
  );

  function automatic int m_slots();
    return (m_depth == 0) ? 8 : (m_depth == 1) ? 4 : 2;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  task automatic compare();
    int s, thr, sz;
    logic [31:0] w;
    bit chg;
    s   = m_slots();
    sz  = q.size();
    chg = (int'(cfg_depth) != m_depth);
    thr = int'(cfg_req) + 1;
    if (thr > s - 1) thr = s - 1;                                  // R3 clamp
    chk("R1 in_ready", {31'b0, in_ready}, {31'b0, (sz < s) && !chg});
    chk("R1 full",     {31'b0, full},     {31'b0, sz == s});
    chk("R1 level",    {28'b0, level},    32'(sz));
    chk("R2/R3 mem_req", {31'b0, mem_req}, {31'b0, (s - sz) >= thr});
    chk("R5 out_valid", {31'b0, out_valid}, {31'b0, sz > 0});
    chk("R8 underrun",  {31'b0, underrun},  {31'b0, m_und});
    if (sz > 0) begin
      w = q[0];
      if (cfg_half) chk("R6 out_data", out_data, {16'b0, m_hsel ? w[31:16] : w[15:0]});
      else          chk("R5 out_data", out_data, w);
    end
  endtask

  task automatic model_step();
    bit ready, chg;
    chg   = (int'(cfg_depth) != m_depth);
    ready = (q.size() < m_slots()) && !chg;
    if (underrun_clr) m_und = 0;
    if (chg) begin                                                 // R4
      q.delete();
      m_lo_have = 0; m_hsel = 0;
      m_depth = int'(cfg_depth);
      return;
    end
    if (out_pop) begin
      if (q.size() == 0) m_und = 1;
      else if (cfg_half) begin
        if (m_hsel) begin void'(q.pop_front()); m_hsel = 0; end
        else m_hsel = 1;
      end else begin
        void'(q.pop_front()); m_hsel = 0;
      end
    end
    if (in_valid && ready) begin
      if (cfg_narrow) begin                                        // R7
        if (!m_lo_have) begin m_lo = in_data[15:0]; m_lo_have = 1; end
        else begin q.push_back({in_data[15:0], m_lo}); m_lo_have = 0; end
      end else q.push_back(in_data);
    end
  endtask

  task automatic cyc(input bit v, input logic [31:0] d, input bit p, input bit c);
    in_valid = v; in_data = d; out_pop = p; underrun_clr = c;
    #1;
    compare();
    model_step();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_depth = 0;
    // R9: reset state
    cyc(0, 0, 0, 0);

    // R1/R2: fill 8 slots, ninth push refused
    for (int i = 0; i < 9; i++) cyc(1, 32'hA000_0000 + i, 0, 0);
    // R5: drain in order
    for (int i = 0; i < 9; i++) cyc(0, 0, 1, 0);

    // R2: each request code against several fill levels
    for (int r = 0; r < 4; r++) begin
      cfg_req = 2'(r);
      for (int i = 0; i < 6; i++) cyc(1, 32'hB000_0000 + i, 0, 0);
      for (int i = 0; i < 6; i++) cyc(0, 0, 1, 0);
    end

    // R4: depth change with content stored, push and pop in same cycle discarded
    for (int i = 0; i < 5; i++) cyc(1, 32'hC000_0000 + i, 0, 0);
    cfg_depth = 2'd1;
    cyc(1, 32'hDEAD_BEEF, 1, 0);
    // R1/R3: four slots, code 3 clamps to three free
    cfg_req = 2'd3;
    for (int i = 0; i < 6; i++) cyc(1, 32'hC100_0000 + i, 0, 0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 0);
    // R3: two slots request whenever one is free
    cfg_depth = 2'd2;
    for (int i = 0; i < 4; i++) cyc(1, 32'hC200_0000 + i, 0, 0);
    cfg_depth = 2'd3;
    for (int i = 0; i < 4; i++) cyc(1, 32'hC300_0000 + i, 0, 0);
    cfg_depth = 2'd0; cfg_req = 2'd1;
    cyc(0, 0, 0, 0);

    // R6: half output mode, low half first
    cfg_half = 1'b1;
    cyc(1, 32'h1234_5678, 0, 0);
    cyc(1, 32'h9ABC_DEF0, 0, 0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 0);
    cfg_half = 1'b0;

    // R7: narrow memory path, two pushes per word
    cfg_narrow = 1'b1;
    for (int i = 0; i < 5; i++) cyc(1, 32'hFFFF_0000 + 32'(16'h1110 + i), 0, 0);
    cfg_narrow = 1'b0;
    cyc(1, 32'h5555_AAAA, 0, 0);
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0);

    // R8: underrun sticky, clear, set wins over clear
    cyc(0, 0, 1, 0);
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 1);
    cyc(0, 0, 1, 0);
    cyc(0, 0, 1, 1);
    cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 0);

    // random traffic: partial halves and pairs across depth changes (R4/R6/R7)
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 99) < 3) cfg_depth = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 99) < 5) cfg_half = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 99) < 5) cfg_narrow = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 99) < 5) cfg_req = 2'($urandom_range(0, 3));
      cyc(1'($urandom_range(0, 1)), $urandom, 1'($urandom_range(0, 2) == 0),
          1'($urandom_range(0, 9) == 0));
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule